// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits inside a byte-wide flash memory model. It watches synchronous bus write cycles and recognises the multi-write unlock and command sequences that select device operations. Every command opens with two unlock writes. A third write picks the operation. Program then takes one more write for its target, and erase takes a second unlock pair followed by a final code.

When a sequence completes, the block sends a one-clock request to the rest of the device: return to read mode, program a byte (with its address and data), start a chip erase, or load one sector for erase. While the embedded-algorithm engine reports busy, writes are dropped. Any write that does not fit the expected next step sends the decoder back to its idle read state. The decoder leaves reset in that read state, so array reads need no command first.

After a sector has been loaded, further sector-select writes may follow directly, with no new unlock. This window stays open until the engine raises busy or a different write arrives.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `read_mode` is 1 and all four request outputs are 0.
- R2: The writes AAh@5555h, 55h@2AAAh, F0h@5555h raise `req_reset` for exactly the clock cycle after the last of them.
- R3: The writes AAh@5555h, 55h@2AAAh, A0h@5555h, then any write D@A raise `req_prog` in the cycle after that last write, with `prog_addr`=A (all 17 bits) and `prog_data`=D.
- R4: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h raise `req_chip_erase` in the cycle after the last write.
- R5: The same five-write prefix as R4, followed by 30h written to any address A, raises `req_sector_erase` with `sector_sel` = A[16:14].
- R6: Command address matching compares only address bits 14..0, so bits 15 and 16 may take any value in unlock and command writes.
- R7: A write whose address or data does not match the expected next step returns the decoder to idle (`read_mode`=1) and issues no request.
- R8: While `alg_busy` is 1, writes change no decoder state and raise no request.
- R9: At most one request output is high in any cycle. A program, chip-erase or reset request never lasts two consecutive cycles.
- R10: After a sector load, each further 30h write (at any address, without unlock) loads the sector it addresses. A write of any other data raises `req_reset` and returns to idle. `alg_busy` going high closes the window without a request.
- R11: `read_mode` is 1 exactly when no command sequence is partly entered. It is 0 from the first accepted unlock write until the sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| wr_stb | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data byte |
| alg_busy | input | 1 | Embedded program/erase algorithm running |
| read_mode | output | 1 | Decoder idle, array in read mode |
| req_reset | output | 1 | Pulse: return to read mode |
| req_prog | output | 1 | Pulse: program one byte |
| prog_addr | output | 17 | Address of byte to program |
| prog_data | output | 8 | Data to program |
| req_chip_erase | output | 1 | Pulse: erase the whole array |
| req_sector_erase | output | 1 | Pulse: add sector to the erase set |
| sector_sel | output | 3 | Sector index for the sector-load pulse |

## Verification
Complete sequences for reset, program, chip erase and sector erase check that each final code is routed to its own request and to no other. Unlock writes with bits 15 and 16 set show whether those bits are truly ignored. Corrupted unlock bytes and bare command codes sent without any unlock separate strict sequencing from lenient decoding. Writes made while busy, in the middle of a sequence, confirm that the partial state survives untouched. The multi-sector window is opened and then closed both by busy and by a foreign write, which tells apart the two exits from the window.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_UNL1, ST_UNL2, ST_PROG, ST_ESET, ST_EUNL1, ST_EUNL2, ST_SLOAD
   } seq_state_t;

   typedef struct packed {
      logic rst;
      logic prog;
      logic chip;
      logic sect;
   } req_t;

   localparam logic [7:0] CODE_UNLOCK_A = 8'hAA;
   localparam logic [7:0] CODE_UNLOCK_B = 8'h55;
   localparam logic [7:0] CODE_RESET    = 8'hF0;
   localparam logic [7:0] CODE_PROG     = 8'hA0;
   localparam logic [7:0] CODE_ESETUP   = 8'h80;
   localparam logic [7:0] CODE_CHIP     = 8'h10;
   localparam logic [7:0] CODE_SECT     = 8'h30;

   localparam logic [14:0] ADR_FIRST  = 15'h5555;
   localparam logic [14:0] ADR_SECOND = 15'h2AAA;
endpackage

// File: rtl/fcd_addr_match.sv
module fcd_addr_match #(
   parameter int MATCH_W = 15
) (
   input  logic [MATCH_W-1:0] addr_lo,
   output logic               at_first,
   output logic               at_second
);
   import flash_cmd_pkg::*;

   localparam logic [MATCH_W-1:0] KEY_FIRST  = MATCH_W'(ADR_FIRST);
   localparam logic [MATCH_W-1:0] KEY_SECOND = MATCH_W'(ADR_SECOND);

   generate
      if (MATCH_W < 14 || MATCH_W > 15) begin : g_bad_w
         $error("fcd_addr_match: MATCH_W must be 14 or 15");
      end
   endgenerate

   assign at_first  = (addr_lo == KEY_FIRST);
   assign at_second = (addr_lo == KEY_SECOND);
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq #(
   parameter int DATA_W       = 8,
   parameter bit MULTI_SECTOR = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_stb,
   input  logic                       alg_busy,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic                       at_first,
   input  logic                       at_second,
   output flash_cmd_pkg::seq_state_t  state_q,
   output flash_cmd_pkg::req_t        req_nx
);
   import flash_cmd_pkg::*;

   seq_state_t state_nx;
   seq_state_t after_sect;
   logic       accept;

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("fcd_seq: DATA_W must be 8");
      end
      if (MULTI_SECTOR) begin : g_multi
         assign after_sect = ST_SLOAD;
      end else begin : g_single
         assign after_sect = ST_IDLE;
      end
   endgenerate

   assign accept = wr_stb && !alg_busy;

   always_comb begin
      state_nx = state_q;
      req_nx   = '0;
      if (alg_busy) begin
         if (state_q == ST_SLOAD) state_nx = ST_IDLE;
      end else if (accept) begin
         state_nx = ST_IDLE;
         unique case (state_q)
            ST_IDLE:
               if (at_first && wr_data == CODE_UNLOCK_A) state_nx = ST_UNL1;
            ST_UNL1:
               if (at_second && wr_data == CODE_UNLOCK_B) state_nx = ST_UNL2;
            ST_UNL2:
               if (at_first) begin
                  if (wr_data == CODE_RESET)       req_nx.rst = 1'b1;
                  else if (wr_data == CODE_PROG)   state_nx = ST_PROG;
                  else if (wr_data == CODE_ESETUP) state_nx = ST_ESET;
               end
            ST_PROG:
               req_nx.prog = 1'b1;
            ST_ESET:
               if (at_first && wr_data == CODE_UNLOCK_A) state_nx = ST_EUNL1;
            ST_EUNL1:
               if (at_second && wr_data == CODE_UNLOCK_B) state_nx = ST_EUNL2;
            ST_EUNL2:
               if (at_first && wr_data == CODE_CHIP) begin
                  req_nx.chip = 1'b1;
               end else if (wr_data == CODE_SECT) begin
                  req_nx.sect = 1'b1;
                  state_nx    = after_sect;
               end
            ST_SLOAD:
               if (wr_data == CODE_SECT) begin
                  req_nx.sect = 1'b1;
                  state_nx    = ST_SLOAD;
               end else begin
                  req_nx.rst = 1'b1;
               end
            default: state_nx = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_nx;
   end

   // R8: a busy engine freezes any sequence other than the sector window
   assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (alg_busy && state_q != ST_SLOAD) |=> state_q == $past(state_q));

   // R10: busy during the sector window always ends it
   assert_window_close_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (alg_busy && state_q == ST_SLOAD) |=> state_q == ST_IDLE);
endmodule

// File: rtl/fcd_req_reg.sv
module fcd_req_reg #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8,
   parameter int SECT_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  flash_cmd_pkg::req_t  req_nx,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   output flash_cmd_pkg::req_t  req_q,
   output logic [ADDR_W-1:0]    prog_addr,
   output logic [DATA_W-1:0]    prog_data,
   output logic [SECT_W-1:0]    sector_sel
);
   localparam int SECT_LSB = ADDR_W - SECT_W;

   generate
      if (SECT_W < 1 || SECT_W >= ADDR_W) begin : g_bad_sect
         $error("fcd_req_reg: SECT_W out of range");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q      <= '0;
         prog_addr  <= '0;
         prog_data  <= '0;
         sector_sel <= '0;
      end else begin
         req_q <= req_nx;
         if (req_nx.prog) begin
            prog_addr <= wr_addr;
            prog_data <= wr_data;
         end
         if (req_nx.sect) sector_sel <= wr_addr[ADDR_W-1:SECT_LSB];
      end
   end

   // R3: program target follows the final write
   assert_prog_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_q.prog |-> (prog_addr == $past(wr_addr) && prog_data == $past(wr_data)));

   // R5: sector index comes from the top address bits of the loading write
   assert_sector_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_q.sect |-> sector_sel == $past(wr_addr[ADDR_W-1:SECT_LSB]));

   // R9: only one request at a time
   assert_one_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_q));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
   parameter int ADDR_W       = 17,
   parameter int DATA_W       = 8,
   parameter int SECT_W       = 3,
   parameter int MATCH_W      = 15,
   parameter bit MULTI_SECTOR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              alg_busy,
   output logic              read_mode,
   output logic              req_reset,
   output logic              req_prog,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic              req_chip_erase,
   output logic              req_sector_erase,
   output logic [SECT_W-1:0] sector_sel
);
   import flash_cmd_pkg::*;

   generate
      if (MATCH_W > ADDR_W) begin : g_bad_match
         $error("flash_cmd_decoder: MATCH_W exceeds ADDR_W");
      end
   endgenerate

   logic       at_first, at_second;
   seq_state_t state_q;
   req_t       req_nx, req_q;

   fcd_addr_match #(.MATCH_W(MATCH_W)) u_match (
      .addr_lo  (wr_addr[MATCH_W-1:0]),
      .at_first (at_first),
      .at_second(at_second)
   );

   fcd_seq #(.DATA_W(DATA_W), .MULTI_SECTOR(MULTI_SECTOR)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_stb),
      .alg_busy (alg_busy),
      .wr_data  (wr_data),
      .at_first (at_first),
      .at_second(at_second),
      .state_q  (state_q),
      .req_nx   (req_nx)
   );

   fcd_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_nx    (req_nx),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .req_q     (req_q),
      .prog_addr (prog_addr),
      .prog_data (prog_data),
      .sector_sel(sector_sel)
   );

   assign read_mode        = (state_q == ST_IDLE);
   assign req_reset        = req_q.rst;
   assign req_prog         = req_q.prog;
   assign req_chip_erase   = req_q.chip;
   assign req_sector_erase = req_q.sect;

   // R8: a write made while busy never produces a request
   assert_busy_no_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      alg_busy |=> !(req_reset || req_prog || req_chip_erase || req_sector_erase));

   // R9: single-cycle pulses
   assert_prog_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_prog |=> !req_prog);
   assert_chip_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_chip_erase |=> !req_chip_erase);
   assert_reset_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_reset |=> !req_reset);

   // R11: a finished program or chip erase leaves the decoder idle
   assert_idle_after_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_prog || req_chip_erase) |-> read_mode);
endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0;
   logic [16:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        alg_busy = 1'b0;
   logic        read_mode, req_reset, req_prog, req_chip_erase, req_sector_erase;
   logic [16:0] prog_addr;
   logic [7:0]  prog_data;
   logic [2:0]  sector_sel;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   flash_cmd_decoder u0 (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .alg_busy(alg_busy), .read_mode(read_mode), .req_reset(req_reset),
      .req_prog(req_prog), .prog_addr(prog_addr), .prog_data(prog_data),
      .req_chip_erase(req_chip_erase), .req_sector_erase(req_sector_erase),
      .sector_sel(sector_sel)
   );

   // Behavioural reference: step counts accepted writes of the current sequence
   int          step;      // 0 idle,1 AA,2 AA55,3 await target,4 80,5 80AA,6 80AA55,7 window
   bit          m_rst, m_prog, m_chip, m_sect;
   logic [16:0] m_paddr;
   logic [7:0]  m_pdata;
   logic [2:0]  m_sect_sel;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step = 0; m_rst = 0; m_prog = 0; m_chip = 0; m_sect = 0;
         m_paddr = '0; m_pdata = '0; m_sect_sel = '0;
      end else begin
         bit a1, a2;
         int nxt;
         m_rst = 0; m_prog = 0; m_chip = 0; m_sect = 0;
         a1 = (wr_addr[14:0] == 15'h5555);
         a2 = (wr_addr[14:0] == 15'h2AAA);
         if (alg_busy) begin
            if (step == 7) step = 0;
         end else if (wr_stb) begin
            nxt = 0;
            if ((step == 0 || step == 4) && a1 && wr_data == 8'hAA) nxt = step + 1;
            else if ((step == 1 || step == 5) && a2 && wr_data == 8'h55) nxt = step + 1;
            else if (step == 2 && a1 && wr_data == 8'hF0) m_rst = 1;
            else if (step == 2 && a1 && wr_data == 8'hA0) nxt = 3;
            else if (step == 2 && a1 && wr_data == 8'h80) nxt = 4;
            else if (step == 3) begin
               m_prog = 1; m_paddr = wr_addr; m_pdata = wr_data;
            end else if (step == 6 && a1 && wr_data == 8'h10) m_chip = 1;
            else if ((step == 6 || step == 7) && wr_data == 8'h30) begin
               m_sect = 1; m_sect_sel = wr_addr[16:14]; nxt = 7;
            end else if (step == 7) m_rst = 1;
            step = nxt;
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R11 read_mode", 32'(read_mode), 32'(step == 0));
         check("R2 req_reset", 32'(req_reset), 32'(m_rst));
         check("R3 req_prog", 32'(req_prog), 32'(m_prog));
         check("R4 req_chip_erase", 32'(req_chip_erase), 32'(m_chip));
         check("R5 req_sector_erase", 32'(req_sector_erase), 32'(m_sect));
         if (m_prog) begin
            check("R3 prog_addr", 32'(prog_addr), 32'(m_paddr));
            check("R3 prog_data", 32'(prog_data), 32'(m_pdata));
         end
         if (m_sect) check("R5 sector_sel", 32'(sector_sel), 32'(m_sect_sel));
         check("R9 onehot", 32'($countones({req_reset, req_prog, req_chip_erase, req_sector_erase}) <= 1), 32'd1);
      end
   end

   // Called at a falling edge; returns at the falling edge after the write is taken
   task automatic wr(input logic [16:0] a, input logic [7:0] d);
      wr_stb = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic unlock(input logic [16:0] hi);
      wr(17'h05555 | hi, 8'hAA);
      wr(17'h02AAA | hi, 8'h55);
   endtask

   task automatic finish_run;
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #400000;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 read_mode", 32'(read_mode), 32'd1);
      check("R1 requests", 32'({req_reset, req_prog, req_chip_erase, req_sector_erase}), 32'd0);

      // R2 reset command
      unlock(17'h0); wr(17'h05555, 8'hF0);
      check("R2 req_reset", 32'(req_reset), 32'd1);
      @(negedge clk);
      check("R9 reset one cycle", 32'(req_reset), 32'd0);

      // R3 program, R11 read_mode during sequence
      wr(17'h05555, 8'hAA);
      check("R11 read_mode mid", 32'(read_mode), 32'd0);
      wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
      wr(17'h12345, 8'h5A);
      check("R3 req_prog", 32'(req_prog), 32'd1);
      check("R3 prog_addr", 32'(prog_addr), 32'h12345);
      check("R3 prog_data", 32'(prog_data), 32'h5A);
      check("R11 idle after prog", 32'(read_mode), 32'd1);

      // R4 chip erase
      unlock(17'h0); wr(17'h05555, 8'h80); unlock(17'h0); wr(17'h05555, 8'h10);
      check("R4 req_chip_erase", 32'(req_chip_erase), 32'd1);

      // R5 sector erase, R10 window
      unlock(17'h0); wr(17'h05555, 8'h80); unlock(17'h0); wr(17'h18000, 8'h30);
      check("R5 req_sector_erase", 32'(req_sector_erase), 32'd1);
      check("R5 sector_sel", 32'(sector_sel), 32'd6);
      wr(17'h04010, 8'h30);
      check("R10 extra sector", 32'(req_sector_erase), 32'd1);
      check("R10 extra sector_sel", 32'(sector_sel), 32'd1);
      alg_busy = 1'b1; @(negedge clk);
      check("R10 busy closes window", 32'(read_mode), 32'd1);
      check("R10 no request on close", 32'(req_reset), 32'd0);
      alg_busy = 1'b0; @(negedge clk);

      // R10 foreign write in window
      unlock(17'h0); wr(17'h05555, 8'h80); unlock(17'h0); wr(17'h1C000, 8'h30);
      wr(17'h05555, 8'hAA);
      check("R10 foreign write resets", 32'(req_reset), 32'd1);
      check("R10 idle after foreign", 32'(read_mode), 32'd1);

      // R6 bits 15 and 16 ignored in command addresses
      unlock(17'h18000); wr(17'h0D555, 8'hA0); wr(17'h00007, 8'hC3);
      check("R6 prog via high-bit addresses", 32'(req_prog), 32'd1);
      check("R6 prog_addr", 32'(prog_addr), 32'h7);

      // R7 mismatches
      wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h54);
      check("R7 bad unlock idle", 32'(read_mode), 32'd1);
      wr(17'h05555, 8'hF0);
      check("R7 bare code no request", 32'(req_reset), 32'd0);
      unlock(17'h0); wr(17'h05554, 8'hA0); wr(17'h00100, 8'h11);
      check("R7 wrong cmd address no prog", 32'(req_prog), 32'd0);
      unlock(17'h0); wr(17'h05555, 8'h80); unlock(17'h0); wr(17'h05555, 8'h20);
      check("R7 bad erase code idle", 32'(read_mode), 32'd1);
      check("R7 bad erase code no req", 32'({req_chip_erase, req_sector_erase}), 32'd0);

      // R8 writes while busy leave partial sequence intact
      wr(17'h05555, 8'hAA);
      alg_busy = 1'b1;
      wr(17'h00000, 8'h00);
      wr(17'h05555, 8'hF0);
      check("R8 no request while busy", 32'(req_reset), 32'd0);
      check("R8 state kept while busy", 32'(read_mode), 32'd0);
      alg_busy = 1'b0;
      wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hF0);
      check("R8 sequence resumes", 32'(req_reset), 32'd1);

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule